// File: doc/BRIEF.md
# Pairwise Tree Summation Engine

This block adds up a vector of N words, where N is a power of two, by pairwise halving inside a register array. A start pulse begins a run. The engine uses one step to sample the parallel input vector and a second step to copy the samples, zero-extended, into a working array of slots. It then runs log2(N) halving rounds. In round h, each lane whose zero-based index j is below N/2^h replaces slot j with the sum of slots 2j and 2j+1. All lanes read the values left by the previous round before any lane writes, so the array never holds a mix of old and new sums within a round.

The sum from the last round lands in lane 0. That lane copies it into the result register, and the engine gives a one-cycle done pulse. The slots are W + log2(N) bits wide, so no carry is lost. A step counter counts every busy cycle. When a run ends it reads 2 + log2(N), which is the ideal parallel step count for this reduction. The surrounding logic should treat the block as a fixed-latency coprocessor: pulse start while the engine is idle, hold the vector for one more cycle, and wait for done.

Top module: `tree_sum_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, busy, done, result and stepCount all read 0.
- R2: A start seen while the engine is idle is accepted on that clock edge. busy is high from the next cycle and stays high for exactly 2 + log2(N) cycles.
- R3: inVec is sampled on the edge that follows the accepting edge. Word i sits at bits [i*W +: W], with i = 0 first. Changes to inVec after that edge do not affect the run.
- R4: The result of a run equals the sum of all N sampled words, each zero-extended to W + log2(N) bits.
- R5: done is high for exactly one cycle, in the cycle after the last round, and busy is low in that cycle.
- R6: stepCount clears to 0 when a start is accepted and increases by one at the end of every busy cycle. It reads 2 + log2(N) while done is high, and holds that value until the next accepted start.
- R7: A start seen while busy is ignored. The running sum, its done timing and its step count are unchanged.
- R8: result changes only on the edge that raises done. Between runs it holds the last total.
- R9: When every word is 2^W - 1, the result equals N*(2^W - 1) with no wrap.
- R10: A start given in the cycle where done is high is accepted, and it begins a new run of the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Run request, taken only while idle |
| inVec | input | N*W | Packed input words, word 0 in the low bits |
| result | output | W+log2(N) | Total of the last completed run |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle completion pulse |
| stepCount | output | clog2(log2(N)+3)+1 | Steps counted in the current or last run |

## Verification
The start edge is counted as edge 0. busy is due one cycle after it. inVec is sampled on edge 1. The result, done and a step count of 2 + log2(N) are all due on edge 2 + log2(N), and done falls one edge later. The bench drives inputs and samples outputs on the falling edge. It counts falling edges from the accepting edge, checks busy at every intermediate edge, and checks the final values at exactly the due edge. It checks ignored starts and late inVec changes at the ports by confirming that the total and its timing match the vector sampled on edge 1.

// File: rtl/tree_sum_pkg.sv
package tree_sum_pkg;
  localparam int ROUND_W = 8;

  typedef struct packed {
    logic               captureEn;
    logic               loadEn;
    logic               roundEn;
    logic               lastRound;
    logic [ROUND_W-1:0] roundNum;
  } strobe_t;
endpackage

// File: rtl/tree_sum_ctrl.sv
module tree_sum_ctrl
  import tree_sum_pkg::*;
#(
  parameter int LOG = 3,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output strobe_t       strobes,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] stepCount
);
  localparam int STEPS = LOG + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_ROUND} state_t;

  state_t             state;
  logic [ROUND_W-1:0] roundCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      roundCnt  <= '0;
      done      <= 1'b0;
      stepCount <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_READ;
            stepCount <= '0;
          end
        end
        ST_READ: begin
          state     <= ST_WRITE;
          stepCount <= stepCount + 1'b1;
        end
        ST_WRITE: begin
          state     <= ST_ROUND;
          roundCnt  <= ROUND_W'(1);
          stepCount <= stepCount + 1'b1;
        end
        default: begin
          stepCount <= stepCount + 1'b1;
          if (roundCnt == ROUND_W'(LOG)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            roundCnt <= roundCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.captureEn = (state == ST_READ);
    strobes.loadEn    = (state == ST_WRITE);
    strobes.roundEn   = (state == ST_ROUND);
    strobes.lastRound = (state == ST_ROUND) && (roundCnt == ROUND_W'(LOG));
    strobes.roundNum  = roundCnt;
  end

  assign busy = (state != ST_IDLE);

  // R5: completion pulse only while idle, and never two cycles in a row
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6, R7: counter advances every busy cycle, so a start while busy cannot clear it
  assert_step_advance_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (stepCount == CW'($past(stepCount) + 1'b1)));
  assert_step_total_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (stepCount == CW'(STEPS)));
endmodule

// File: rtl/tree_sum_datapath.sv
module tree_sum_datapath
  import tree_sum_pkg::*;
#(
  parameter int N   = 8,
  parameter int W   = 8,
  parameter int AW  = 11
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strobes,
  input  logic [N*W-1:0] inVec,
  output logic [AW-1:0]  result
);
  logic [W-1:0]  stage [N];
  logic [AW-1:0] slot  [N];

  for (genvar j = 0; j < N; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage[j] <= '0;
      end else if (strobes.captureEn) begin
        stage[j] <= inVec[j*W +: W];
      end
    end

    if (j < N/2) begin : g_active
      logic laneActive;
      assign laneActive = (j < (N >> strobes.roundNum));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slot[j] <= '0;
        end else if (strobes.loadEn) begin
          slot[j] <= AW'(stage[j]);
        end else if (strobes.roundEn && laneActive) begin
          slot[j] <= slot[2*j] + slot[2*j+1];
        end
      end
    end else begin : g_upper
      always_ff @(posedge clk) begin
        if (!rstN) begin
          slot[j] <= '0;
        end else if (strobes.loadEn) begin
          slot[j] <= AW'(stage[j]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (strobes.roundEn && strobes.lastRound) begin
      result <= slot[0] + slot[1];
    end
  end

  // phases of a run are mutually exclusive
  assert_phase_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.captureEn, strobes.loadEn, strobes.roundEn}));
  // R8: result moves only on the final round
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.roundEn && strobes.lastRound) |=> $stable(result));
endmodule

// File: rtl/tree_sum_top.sv
module tree_sum_top
  import tree_sum_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  localparam int LOG = $clog2(N),
  localparam int AW  = W + LOG,
  localparam int CW  = $clog2(LOG + 3) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N*W-1:0] inVec,
  output logic [AW-1:0]  result,
  output logic           busy,
  output logic           done,
  output logic [CW-1:0]  stepCount
);
  strobe_t strobes;

  tree_sum_ctrl #(.LOG(LOG), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .strobes   (strobes),
    .busy      (busy),
    .done      (done),
    .stepCount (stepCount)
  );

  tree_sum_datapath #(.N(N), .W(W), .AW(AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inVec   (inVec),
    .result  (result)
  );

  initial begin
    assert_param_pow2_R4: assert ((N >= 2) && ((1 << LOG) == N));
  end
endmodule

// File: tb/tree_sum_top_tb.sv
module tree_sum_top_tb;
  localparam int N   = 8;
  localparam int W   = 8;
  localparam int LOG = $clog2(N);
  localparam int AW  = W + LOG;
  localparam int CW  = $clog2(LOG + 3) + 1;
  localparam int STEPS = LOG + 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] inVec = '0;
  logic [AW-1:0]  result;
  logic           busy;
  logic           done;
  logic [CW-1:0]  stepCount;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tree_sum_top #(.N(N), .W(W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inVec(inVec),
    .result(result), .busy(busy), .done(done), .stepCount(stepCount)
  );

  function automatic logic [AW-1:0] refSum(logic [N*W-1:0] v);
    logic [AW-1:0] acc = '0;
    for (int i = 0; i < N; i++) acc = acc + AW'(v[i*W +: W]);
    return acc;
  endfunction

  function automatic logic [N*W-1:0] randVec();
    logic [N*W-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // start driven at a falling edge; edge 0 follows. Done due at edge STEPS.
  task automatic runOne(logic [N*W-1:0] vec, bit pokeBusy, bit tail);
    logic [AW-1:0] expSum = refSum(vec);
    start = 1'b1;
    inVec = vec;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after accept", busy, 1);
    check("R6 step cleared", stepCount, 0);
    for (int c = 1; c <= STEPS; c++) begin
      @(negedge clk);
      if (c == 1) inVec = ~vec;
      if (c < STEPS) begin
        if (busy !== 1'b1 || done !== 1'b0)
          check("R2 busy window", {busy, done}, 2'b10);
        if (c == 2 && pokeBusy) begin
          start = 1'b1;
          inVec = randVec();
        end else begin
          start = 1'b0;
        end
      end
    end
    start = 1'b0;
    check("R5 done pulse", done, 1);
    check("R5 busy low at done", busy, 0);
    check("R4 result", result, expSum);
    check("R6 step total", stepCount, STEPS);
    if (tail) begin
      @(negedge clk);
      check("R5 done falls", done, 0);
      check("R8 result holds", result, expSum);
      check("R6 step holds", stepCount, STEPS);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [N*W-1:0] v;
    int seedDummy;
    seedDummy = $urandom(32'd20240517);
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 result in reset", result, 0);
    check("R1 step in reset", stepCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 result after reset", result, 0);

    runOne('0, 1'b0, 1'b1);                     // R4 all zero
    runOne({N*W{1'b1}}, 1'b0, 1'b1);            // R9 all ones
    check("R9 full-scale total", result, N * ((1 << W) - 1));
    v = '0; v[(N-1)*W +: W] = W'(8'hA5);
    runOne(v, 1'b0, 1'b1);                      // R3 top word position
    v = '0; v[W-1:0] = W'(8'h3C);
    runOne(v, 1'b0, 1'b1);                      // R3 bottom word position
    runOne(randVec(), 1'b1, 1'b1);              // R7 start while busy ignored
    @(negedge clk);
    check("R7 no extra run", busy, 0);
    runOne(randVec(), 1'b0, 1'b0);              // R10 back-to-back
    runOne(randVec(), 1'b0, 1'b1);              // R10 second run
    for (int k = 0; k < 20; k++) begin
      runOne(randVec(), (k % 3) == 0, (k % 2) == 0);
    end
    repeat (4) @(negedge clk);
    check("R8 idle hold busy", busy, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule